// File: doc/BRIEF.md
# EDO DRAM Strobe Sequencer Controller

This block sits between a simple synchronous request port and a 16-bit asynchronous extended-data-out DRAM that has a lower and an upper column strobe. A host request carries an address, write data, a two-bit byte enable and a write flag. The controller turns each accepted request into a timed sequence on the row strobe, the two column strobes, write enable, output enable and a multiplexed address bus. A read returns its data with a one-cycle valid pulse. The request address is split into a row field in the upper bits and a column field in the lower bits.

Out of reset the controller keeps every strobe inactive for a start-up pause. The length of the pause is given in microseconds and turned into clock cycles by a clock-frequency parameter. It then issues a fixed number of column-before-row refresh cycles, and only after those does it accept host traffic. From then on an interval counter requests a refresh at a fixed period. A pending refresh wins over a waiting host request whenever the sequencer returns to idle. Every write is an early write, so write enable is already low before either column strobe falls and the device never drives the data bus during a write. All timing values are parameters counted in clock cycles.

Top module: `edo_ctrl`

## Requirements
- R1: For PAUSE_US*CLK_MHZ clock cycles after reset, the row strobe and both column strobes stay high, and req_ready stays low.
- R2: After the pause, exactly INIT_REF refresh cycles are issued. req_ready stays low until the last of them and its row precharge have ended, and no host access occurs before then.
- R3: A refresh cycle drives both column strobes low for T_CSR cycles before the row strobe falls. Write enable and output enable stay high and the data bus is not driven during it.
- R4: A request with byte enable 2'b11 asserts both column strobes. A word written and then read back at the same address returns the same 16 bits.
- R5: Byte enable bit 0 selects the lower strobe and data bits 7:0. Bit 1 selects the upper strobe and bits 15:8. A byte write leaves the other lane of the stored word unchanged, and a byte read returns zero in the lane that was not selected.
- R6: A write drives write enable low and the data bus from the cycle the row strobe falls, which is at least T_RCD+1 cycles before the column strobe falls. Output enable stays high during the write. A read keeps write enable high for the whole cycle, and the data bus is never driven while output enable is low.
- R7: The row field of the request address is on the address bus when the row strobe falls. The column field is placed on the bus one cycle before the column strobes fall and stays stable while they are low.
- R8: Read data is sampled T_ACC cycles after the column strobes fall and presented with a valid pulse one cycle long. The pulse is seen T_RCD+1+T_ACC cycles after the accepting clock edge.
- R9: A request with byte enable 2'b00 produces no strobe activity. A zero-enable read returns data zero with its valid pulse one cycle after acceptance, and a zero-enable write changes nothing.
- R10: After initialization a refresh is requested every REF_INT cycles. It is served before any host request that is waiting, so refreshes keep occurring under continuous host traffic.
- R11: Between any two row-strobe low periods, whether refresh or access, the row strobe stays high for at least T_RP cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Request address, row field in the upper bits |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_ready | output | 1 | Request accepted on this edge when valid |
| rsp_valid | output | 1 | One-cycle read-data valid pulse |
| rsp_rdata | output | 16 | Read data, unselected lane zero |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower column strobe, active low |
| dram_ucas_n | output | 1 | Upper column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven toward the device |
| dram_dq_oe | output | 1 | Data bus drive enable |
| dram_dq_in | input | 16 | Data returned by the device |

## Verification
The bench memory model returns a garbage pattern until the column strobe has been low for T_ACC cycles. A controller that samples one cycle early therefore returns wrong data instead of passing by luck, and a wrong latency also shows up as a count mismatch. The bench writes a full word and then overwrites one byte, so a swapped or merged lane enable corrupts the other byte. Zero-enable requests are checked for the absence of strobe activity, because a design that issued a cycle for them would write stale data. Monitors count refreshes issued before req_ready rises, which catches an off-by-one in the start-up sequence. The same monitors catch a refresh with the row strobe falling first, write enable falling with or after the column strobe, a precharge gap that is too short, and a refresh starved by back-to-back reads.

// File: rtl/edo_pkg.sv
package edo_pkg;

  localparam int unsigned DQ_W = 16;

  typedef enum logic [2:0] {
    S_WAIT, S_IDLE, S_RCAS, S_RRAS, S_ROW, S_CADR, S_COL, S_PRE
  } edo_st_e;

  function automatic int unsigned pause_cycles(input int unsigned us, input int unsigned mhz);
    return us * mhz;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // cycles from the accepting edge to the edge that raises rsp_valid
  function automatic int unsigned read_latency(input int unsigned rcd, input int unsigned acc);
    return rcd + 1 + acc;
  endfunction

  function automatic logic [DQ_W-1:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

endpackage

// File: rtl/edo_ref_sched.sv
module edo_ref_sched #(
  parameter int unsigned PAUSE_CYC = 20000,
  parameter int unsigned INIT_REF  = 8,
  parameter int unsigned REF_INT   = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  output logic pause_done,
  output logic init_fin,
  output logic ref_need
);
  localparam int unsigned PW = $clog2(PAUSE_CYC + 1);
  localparam int unsigned IW = $clog2(INIT_REF + 1);
  localparam int unsigned RW = $clog2(REF_INT + 1);

  logic [PW-1:0] pause_cnt;
  logic [IW-1:0] init_left;
  logic [RW-1:0] int_cnt;
  logic          per_pend;
  logic          per_tick;
  logic          init_pend;

  assign pause_done = (pause_cnt == PW'(PAUSE_CYC));
  assign init_pend  = pause_done && (init_left != '0);
  assign init_fin   = pause_done && (init_left == '0);
  assign per_tick   = init_fin && (int_cnt == RW'(REF_INT - 1));
  assign ref_need   = init_pend || per_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pause_cnt <= '0;
      init_left <= IW'(INIT_REF);
      int_cnt   <= '0;
      per_pend  <= 1'b0;
    end else begin
      if (!pause_done) pause_cnt <= pause_cnt + 1'b1;
      if (ref_ack && init_left != '0) init_left <= init_left - 1'b1;
      if (init_fin) int_cnt <= per_tick ? '0 : int_cnt + 1'b1;
      if (per_tick) per_pend <= 1'b1;
      else if (ref_ack && init_fin) per_pend <= 1'b0;
    end
  end

  // R1
  ack_after_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |-> pause_done);

  // R10
  pend_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_pend && !ref_ack) |=> per_pend);

endmodule

// File: rtl/edo_cycle_fsm.sv
module edo_cycle_fsm
  import edo_pkg::*;
#(
  parameter int unsigned ROW_W = 12,
  parameter int unsigned COL_W = 10,
  parameter int unsigned DA_W  = 12,
  parameter int unsigned T_RCD = 2,
  parameter int unsigned T_CAS = 2,
  parameter int unsigned T_ACC = 2,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_CSR = 1,
  parameter int unsigned T_RAS = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pause_done,
  input  logic                   init_fin,
  input  logic                   ref_need,
  output logic                   ref_ack,
  input  logic                   req_valid,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DQ_W-1:0]        req_wdata,
  input  logic [1:0]             req_be,
  output logic                   req_ready,
  output logic                   rsp_valid,
  output logic [DQ_W-1:0]        rsp_rdata,
  output logic [DA_W-1:0]        dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_lcas_n,
  output logic                   dram_ucas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [DQ_W-1:0]        dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DQ_W-1:0]        dram_dq_in
);
  localparam int unsigned TMAX = max2(max2(max2(T_RCD, T_CAS), max2(T_RP, T_CSR)), T_RAS);
  localparam int unsigned CW   = $clog2(TMAX + 1) + 1;
  localparam int unsigned CAP  = T_CAS - T_ACC;

  edo_st_e                st;
  logic [CW-1:0]          cnt;
  logic [ROW_W+COL_W-1:0] addr_q;
  logic [DQ_W-1:0]        wdata_q;
  logic [1:0]             be_q;
  logic                   we_q;

  // named internal events
  logic t_done, req_fire, zero_be, cap_ev, in_access, ras_low;
  assign t_done    = (cnt == '0);
  assign req_ready = (st == S_IDLE) && init_fin && !ref_need;
  assign ref_ack   = (st == S_IDLE) && ref_need;
  assign req_fire  = req_valid && req_ready;
  assign zero_be   = (req_be == 2'b00);
  assign in_access = (st == S_ROW) || (st == S_CADR) || (st == S_COL);
  assign cap_ev    = (st == S_COL) && !we_q && (cnt == CW'(CAP));
  assign ras_low   = in_access || (st == S_RRAS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_WAIT;
      cnt       <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      we_q      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (!t_done) cnt <= cnt - 1'b1;
      unique case (st)
        S_WAIT: if (pause_done) st <= S_IDLE;
        S_IDLE: begin
          if (ref_need) begin
            st  <= S_RCAS;
            cnt <= CW'(T_CSR - 1);
          end else if (req_fire) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
            we_q    <= req_we;
            if (zero_be) begin
              rsp_valid <= !req_we;
              rsp_rdata <= '0;
            end else begin
              st  <= S_ROW;
              cnt <= CW'(T_RCD - 1);
            end
          end
        end
        S_RCAS: if (t_done) begin st <= S_RRAS; cnt <= CW'(T_RAS - 1); end
        S_RRAS: if (t_done) begin st <= S_PRE;  cnt <= CW'(T_RP - 1);  end
        S_ROW:  if (t_done) st <= S_CADR;
        S_CADR: begin st <= S_COL; cnt <= CW'(T_CAS - 1); end
        S_COL: begin
          if (cap_ev) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= dram_dq_in & lane_mask(be_q);
          end
          if (t_done) begin st <= S_PRE; cnt <= CW'(T_RP - 1); end
        end
        S_PRE:  if (t_done) st <= S_IDLE;
        default: st <= S_WAIT;
      endcase
    end
  end

  logic [DA_W-1:0] row_a, col_a;
  assign row_a = DA_W'(addr_q[ROW_W+COL_W-1:COL_W]);
  assign col_a = DA_W'(addr_q[COL_W-1:0]);

  assign dram_addr   = ((st == S_CADR) || (st == S_COL)) ? col_a : row_a;
  assign dram_ras_n  = !ras_low;
  assign dram_lcas_n = !((st == S_RCAS) || (st == S_RRAS) || ((st == S_COL) && be_q[0]));
  assign dram_ucas_n = !((st == S_RCAS) || (st == S_RRAS) || ((st == S_COL) && be_q[1]));
  assign dram_we_n   = !(we_q && in_access);
  assign dram_oe_n   = !(!we_q && (st == S_COL));
  assign dram_dq_oe  = we_q && in_access;
  assign dram_dq_out = wdata_q;

  // checker counter: cycles the row strobe has been high, saturating
  logic [CW-1:0] ras_hi_run;
  always_ff @(posedge clk) begin
    if (!rst_n) ras_hi_run <= CW'(TMAX);
    else if (!dram_ras_n) ras_hi_run <= '0;
    else if (ras_hi_run != CW'(TMAX)) ras_hi_run <= ras_hi_run + 1'b1;
  end

  // R1
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_done |-> (dram_ras_n && dram_lcas_n && dram_ucas_n));

  // R3
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_lcas_n) |->
      ($past(!dram_lcas_n && !dram_ucas_n) && dram_we_n && dram_oe_n && !dram_dq_oe));

  // R6
  early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(dram_lcas_n) || $fell(dram_ucas_n)) && !dram_ras_n && !dram_we_n) |->
      ($past(!dram_we_n) && dram_oe_n));

  // R6
  bus_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dram_dq_oe && !dram_oe_n));

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R11
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (ras_hi_run >= CW'(T_RP)));

endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl
  import edo_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 100,
  parameter int unsigned PAUSE_US = 200,
  parameter int unsigned INIT_REF = 8,
  parameter int unsigned REF_INT  = 1560,
  parameter int unsigned ROW_W    = 12,
  parameter int unsigned COL_W    = 10,
  parameter int unsigned T_RCD    = 2,
  parameter int unsigned T_CAS    = 2,
  parameter int unsigned T_ACC    = 2,
  parameter int unsigned T_RP     = 3,
  parameter int unsigned T_CSR    = 1,
  parameter int unsigned T_RAS    = 5,
  localparam int unsigned AW      = ROW_W + COL_W,
  localparam int unsigned DA_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_we,
  input  logic [AW-1:0]   req_addr,
  input  logic [15:0]     req_wdata,
  input  logic [1:0]      req_be,
  output logic            req_ready,
  output logic            rsp_valid,
  output logic [15:0]     rsp_rdata,
  output logic [DA_W-1:0] dram_addr,
  output logic            dram_ras_n,
  output logic            dram_lcas_n,
  output logic            dram_ucas_n,
  output logic            dram_we_n,
  output logic            dram_oe_n,
  output logic [15:0]     dram_dq_out,
  output logic            dram_dq_oe,
  input  logic [15:0]     dram_dq_in
);
  localparam int unsigned PAUSE_CYC = pause_cycles(PAUSE_US, CLK_MHZ);

  logic pause_done, init_fin, ref_need, ref_ack;

  edo_ref_sched #(
    .PAUSE_CYC(PAUSE_CYC), .INIT_REF(INIT_REF), .REF_INT(REF_INT)
  ) u_sched (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack),
    .pause_done(pause_done), .init_fin(init_fin), .ref_need(ref_need)
  );

  edo_cycle_fsm #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DA_W(DA_W),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_ACC(T_ACC),
    .T_RP(T_RP), .T_CSR(T_CSR), .T_RAS(T_RAS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .pause_done(pause_done), .init_fin(init_fin), .ref_need(ref_need), .ref_ack(ref_ack),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  initial begin
    // R8
    acc_fits_chk: assert (T_ACC >= 1 && T_ACC <= T_CAS);
    // R10
    interval_chk: assert (REF_INT >= 2);
  end

endmodule

// File: tb/tb_edo_ctrl.sv
module tb_edo_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ = 1, PAUSE_US = 200, INIT_REF = 8, REF_INT = 300;
  localparam int ROW_W = 4, COL_W = 4;
  localparam int T_RCD = 2, T_CAS = 3, T_ACC = 2, T_RP = 2, T_CSR = 2, T_RAS = 3;
  localparam int PAUSE_CYC = PAUSE_US * CLK_MHZ;
  localparam int READ_LAT  = T_RCD + 1 + T_ACC;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [7:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic [1:0] req_be = 0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [3:0] dram_addr;
  logic ras_n, lcas_n, ucas_n, we_n, oe_n, dq_oe;
  logic [15:0] dq_out, dq_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  edo_ctrl #(.CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .INIT_REF(INIT_REF), .REF_INT(REF_INT),
    .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_ACC(T_ACC),
    .T_RP(T_RP), .T_CSR(T_CSR), .T_RAS(T_RAS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .dram_addr(dram_addr), .dram_ras_n(ras_n), .dram_lcas_n(lcas_n),
    .dram_ucas_n(ucas_n), .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_dq_out(dq_out),
    .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

  int checks = 0, fails = 0;
  int cyc = 0, first_ras = -1;
  int cbr_cnt = 0, cbr_bad = 0, acc_cnt = 0, lfall = 0, ufall = 0;
  int ew_bad = 0, pre_bad = 0, col_bad = 0, clash_bad = 0, ras_hi = 1000, cas_lo = 0;
  logic [15:0] mem [256];
  logic [3:0] row_l = 0;
  logic ras_p = 1, lcas_p = 1, ucas_p = 1, we_p = 1;
  logic [3:0] addr_p = 0;

  always @(posedge clk) begin
    if (rst_n) cyc <= cyc + 1;
    cas_lo <= (lcas_n && ucas_n) ? 0 : cas_lo + 1;
  end

  // device model: data valid only after T_ACC cycles of column strobe low
  assign dq_in = (!oe_n && (cas_lo + 1 >= T_ACC)) ? mem[{row_l, dram_addr}] : 16'hBAD0;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    end else begin
      if (!ras_n && ras_p) begin
        if (first_ras < 0) first_ras = cyc;
        if (ras_hi < T_RP) pre_bad++;
        if (!lcas_n) begin
          cbr_cnt++;
          if (lcas_p || ucas_p || ucas_n || !we_n || !oe_n || dq_oe) cbr_bad++;
        end else begin
          acc_cnt++;
          row_l = dram_addr;
        end
      end
      ras_hi = ras_n ? ras_hi + 1 : 0;
      if (!ras_n && ((!lcas_n && lcas_p) || (!ucas_n && ucas_p))) begin
        if (!lcas_n && lcas_p) lfall++;
        if (!ucas_n && ucas_p) ufall++;
        if (dram_addr != addr_p) col_bad++;
        if (!we_n && (we_p || !oe_n || !dq_oe)) ew_bad++;
      end
      if (!ras_n && (!lcas_n || !ucas_n) && !(lcas_p && ucas_p) && dram_addr != addr_p) col_bad++;
      if (dq_oe && !oe_n) clash_bad++;
      if (!ras_n && !we_n && dq_oe) begin
        if (!lcas_n) mem[{row_l, dram_addr}][7:0]  = dq_out[7:0];
        if (!ucas_n) mem[{row_l, dram_addr}][15:8] = dq_out[15:8];
      end
    end
    ras_p = ras_n; lcas_p = lcas_n; ucas_p = ucas_n; we_p = we_n; addr_p = dram_addr;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic issue(input logic we, input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
    wait_ready();
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
    issue(1'b1, a, d, be);
    wait_ready();
  endtask

  task automatic do_read(input logic [7:0] a, input logic [1:0] be,
                         output logic [15:0] data, output int lat);
    wait_ready();
    req_valid = 1; req_we = 0; req_addr = a; req_be = be;
    lat = 0;
    do begin
      @(negedge clk);
      req_valid = 0;
      lat++;
    end while (!rsp_valid && lat < 60);
    data = rsp_rdata;
  endtask

  task automatic t_reset();
    chk("R1 ras_n in reset", ras_n, 1);
    chk("R1 cas in reset", {lcas_n, ucas_n}, 2'b11);
    chk("R1 ready in reset", req_ready, 0);
  endtask

  task automatic t_init();
    wait_ready();
    chk("R1 pause respected", (first_ras >= PAUSE_CYC) && (first_ras < PAUSE_CYC + 20), 1);
    chk("R2 init refresh count", cbr_cnt, INIT_REF);
    chk("R2 no access during init", acc_cnt, 0);
    chk("R3 refresh strobe order", cbr_bad, 0);
  endtask

  task automatic t_word();
    logic [15:0] d; int lat, l0, u0;
    l0 = lfall; u0 = ufall;
    do_write(8'h35, 16'hA5C3, 2'b11);
    chk("R4 word write both strobes", {lfall - l0, ufall - u0}, {32'd1, 32'd1});
    do_write(8'hC2, 16'h1234, 2'b11);
    do_read(8'h35, 2'b11, d, lat);
    chk("R4 word readback", d, 16'hA5C3);
    chk("R8 read latency", lat, READ_LAT + 1);
    do_read(8'hC2, 2'b11, d, lat);
    chk("R7 other row readback", d, 16'h1234);
  endtask

  task automatic t_bytes();
    logic [15:0] d; int lat, l0, u0;
    do_write(8'h7A, 16'h1122, 2'b11);
    l0 = lfall; u0 = ufall;
    do_write(8'h7A, 16'hEEFF, 2'b10);
    chk("R5 upper write strobes", {lfall - l0, ufall - u0}, {32'd0, 32'd1});
    do_read(8'h7A, 2'b11, d, lat);
    chk("R5 upper byte merged", d, 16'hEE22);
    l0 = lfall; u0 = ufall;
    do_read(8'h7A, 2'b01, d, lat);
    chk("R5 lower read strobes", {lfall - l0, ufall - u0}, {32'd1, 32'd0});
    chk("R5 lower read lane", d, 16'h0022);
    do_write(8'h7A, 16'h3344, 2'b01);
    do_read(8'h7A, 2'b10, d, lat);
    chk("R5 upper read lane", d, 16'hEE00);
  endtask

  task automatic t_zero();
    logic [15:0] d; int lat, a0;
    do_write(8'h11, 16'h5AA5, 2'b11);
    a0 = acc_cnt;
    issue(1'b1, 8'h11, 16'hFFFF, 2'b00);
    repeat (4) @(negedge clk);
    chk("R9 zero write no strobes", acc_cnt - a0, 0);
    a0 = acc_cnt;
    do_read(8'h11, 2'b00, d, lat);
    chk("R9 zero read latency", lat, 1);
    chk("R9 zero read data", d, 0);
    chk("R9 zero read no strobes", acc_cnt - a0, 0);
    do_read(8'h11, 2'b11, d, lat);
    chk("R9 zero write changed nothing", d, 16'h5AA5);
  endtask

  task automatic t_ref_idle();
    int c0;
    wait_ready();
    c0 = cbr_cnt;
    repeat (4 * REF_INT) @(negedge clk);
    chk("R10 idle refresh rate", (cbr_cnt - c0 >= 3) && (cbr_cnt - c0 <= 5), 1);
  endtask

  task automatic t_ref_busy();
    int c0, tend, lat; logic [15:0] d;
    c0 = cbr_cnt; tend = cyc + 4 * REF_INT;
    while (cyc < tend) do_read(8'h35, 2'b11, d, lat);
    chk("R10 refresh under traffic", (cbr_cnt - c0 >= 3) && (cbr_cnt - c0 <= 5), 1);
    chk("R10 data under traffic", d, 16'hA5C3);
  endtask

  task automatic t_monitors();
    chk("R6 early write order", ew_bad, 0);
    chk("R6 bus clash", clash_bad, 0);
    chk("R7 column address stable", col_bad, 0);
    chk("R11 row precharge", pre_bad, 0);
    chk("R3 refresh form overall", cbr_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_init();
    t_word();
    t_bytes();
    t_zero();
    t_ref_idle();
    t_ref_busy();
    t_monitors();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule